// File: doc/BRIEF.md
# Dual-Ramp Time-Difference Digitizer

This block sits behind two threshold comparators that watch a pair of charging ramps, one per sensor channel. Each ramp crosses its threshold after a time that grows with the capacitance on its channel. The block turns the gap between the two crossings into a clock-cycle count. A sign bit records which channel crossed first, so the result is a signed measure of the capacitance imbalance.

The block needs no start command. Once both comparators report a crossing, it publishes the result and raises a reset line that discharges both ramps. It keeps that line high for a minimum stretch, and beyond that until both comparator flags have gone low again. It then releases the line and waits for the next pair of crossings. A timeout ends a conversion where the second channel never crosses. A debug output shows the raw pulse whose width is being measured.

Top module: `rampdiff_digitizer`

## Requirements
- R1: `pulseWidth` equals the exclusive-OR of the two synchronized comparator flags. It is high only while exactly one channel has crossed.
- R2: The result magnitude `result[CNT_W-1:0]` equals the number of clock cycles between the synchronized rising edges of the two flags.
- R3: The sign bit `result[CNT_W]` is 0 when channel A crossed first and 1 when channel B crossed first. It is latched at the first crossing and held for the rest of the conversion.
- R4: When both flags rise in the same cycle, the result is magnitude 0 with the sign bit 0.
- R5: The magnitude saturates at 2^CNT_W-1 when the gap is longer than that.
- R6: `resultValid` is a single-cycle pulse. It is issued in the same cycle that `frontReset` rises after both flags are seen high.
- R7: `frontReset` stays high for at least RST_HOLD cycles, and beyond that until both synchronized flags are low. It then drops on its own, with no external pulse.
- R8: `frontReset` is high from reset onward, so the first conversion starts from discharged ramps.
- R9: If only one flag has risen and the other has not followed within `timeoutLimit` cycles, `timeoutFlag` pulses for one cycle, `frontReset` is raised and no result is published. A gap of exactly `timeoutLimit` cycles still completes normally.
- R10: Each flag passes through a two-flop synchronizer. A flag change reaches `pulseWidth` two clock edges after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flagA | input | 1 | Comparator flag of channel A (asynchronous) |
| flagB | input | 1 | Comparator flag of channel B (asynchronous) |
| timeoutLimit | input | TO_W | Longest gap, in cycles, still accepted as a measurement |
| frontReset | output | 1 | Discharge command to the analog front end |
| pulseWidth | output | 1 | Debug view of the XOR of the synchronized flags |
| result | output | CNT_W+1 | Sign in the MSB, cycle-count magnitude below it |
| resultValid | output | 1 | One-cycle strobe marking a new result |
| timeoutFlag | output | 1 | One-cycle strobe marking an abandoned conversion |

## Verification
The bench builds the block with a 6-bit magnitude, a 10-bit timeout field and an 8-cycle minimum reset hold. With a 6-bit count, saturation is reached by gaps of a few dozen cycles, and a gap of 100 both saturates and sits exactly at the timeout limit. The short hold lets the bench count the exact reset length, and also stretch the reset by holding the flags high. The timeout path is reached in about a hundred cycles.

// File: rtl/rd_pkg.sv
package rd_pkg;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic loadFirst;  // first crossing seen: start count, latch sign
    logic incr;       // one more cycle with exactly one flag high
    logic capture;    // both flags high: publish the result
    logic zeroCap;    // with capture: both rose together, publish zero
  } rd_strobe_t;

  typedef enum logic [1:0] {
    ST_CLEAR = 2'd0,
    ST_WAIT  = 2'd1,
    ST_MEAS  = 2'd2
  } rd_state_t;

endpackage

// File: rtl/rd_datapath.sv
module rd_datapath
  import rd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flagA,
  input  logic             flagB,
  input  rd_strobe_t       strobe,
  output logic             aSync,
  output logic             bSync,
  output logic             pulseWidth,
  output logic [CNT_W:0]   result,
  output logic             resultValid
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam int               NCH     = 2;

  logic [NCH-1:0]   rawFlags;
  logic [NCH-1:0]   syncFlags;
  logic [CNT_W-1:0] count;
  logic             signReg;

  assign rawFlags = {flagB, flagA};

  // Two-flop synchronizer per channel (R10)
  for (genvar ch = 0; ch < NCH; ch++) begin : g_sync
    logic stage0;
    logic stage1;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage0 <= 1'b0;
        stage1 <= 1'b0;
      end else begin
        stage0 <= rawFlags[ch];
        stage1 <= stage0;
      end
    end
    assign syncFlags[ch] = stage1;
  end

  assign aSync      = syncFlags[0];
  assign bSync      = syncFlags[1];
  assign pulseWidth = aSync ^ bSync;

  // Gap counter with saturation, and the sign latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      signReg <= 1'b0;
    end else if (strobe.loadFirst) begin
      count   <= CNT_W'(1);
      signReg <= bSync;
    end else if (strobe.incr) begin
      if (count != CNT_MAX) count <= count + 1'b1;
    end
  end

  // Result register and valid strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result      <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= strobe.capture;
      if (strobe.capture) begin
        if (strobe.zeroCap) result <= '0;
        else                result <= {signReg, count};
      end
    end
  end

  assert_sat_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.incr && !strobe.loadFirst && count == CNT_MAX) |=> (count == CNT_MAX));

  assert_zero_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (resultValid && result[CNT_W-1:0] == '0) |-> !result[CNT_W]);

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid |=> !resultValid);

endmodule

// File: rtl/rd_control.sv
module rd_control
  import rd_pkg::*;
#(
  parameter int TO_W     = 20,
  parameter int RST_HOLD = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            aSync,
  input  logic            bSync,
  input  logic [TO_W-1:0] timeoutLimit,
  output rd_strobe_t      strobe,
  output logic            frontReset,
  output logic            timeoutFlag
);

  localparam int HOLD_W = $clog2(RST_HOLD + 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(RST_HOLD - 1);
  localparam logic [TO_W-1:0]   EL_MAX    = {TO_W{1'b1}};

  rd_state_t         state, nextState;
  logic [HOLD_W-1:0] holdCnt;
  logic [TO_W-1:0]   elapsed;
  logic              holdDone;
  logic              toHit;

  assign holdDone = (holdCnt >= HOLD_LAST);

  always_comb begin
    strobe    = '0;
    toHit     = 1'b0;
    nextState = state;
    unique case (state)
      ST_CLEAR: begin
        if (holdDone && !aSync && !bSync) nextState = ST_WAIT;
      end
      ST_WAIT: begin
        if (aSync && bSync) begin
          strobe.capture = 1'b1;
          strobe.zeroCap = 1'b1;
          nextState      = ST_CLEAR;
        end else if (aSync || bSync) begin
          strobe.loadFirst = 1'b1;
          nextState        = ST_MEAS;
        end
      end
      ST_MEAS: begin
        if (aSync && bSync) begin
          strobe.capture = 1'b1;
          nextState      = ST_CLEAR;
        end else if (elapsed >= timeoutLimit) begin
          toHit     = 1'b1;
          nextState = ST_CLEAR;
        end else begin
          strobe.incr = 1'b1;
        end
      end
      default: nextState = ST_CLEAR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_CLEAR;
      frontReset  <= 1'b1;
      timeoutFlag <= 1'b0;
    end else begin
      state       <= nextState;
      frontReset  <= (nextState == ST_CLEAR);
      timeoutFlag <= toHit;
    end
  end

  // Minimum reset stretch counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                holdCnt <= '0;
    else if (state != ST_CLEAR) holdCnt <= '0;
    else if (!holdDone)        holdCnt <= holdCnt + 1'b1;
  end

  // Cycles elapsed since the first crossing, for the timeout
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 elapsed <= '0;
    else if (strobe.loadFirst)  elapsed <= TO_W'(1);
    else if (strobe.incr && elapsed != EL_MAX) elapsed <= elapsed + 1'b1;
  end

  assert_release_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frontReset) |-> $past(!aSync && !bSync));

  assert_timeout_resets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timeoutFlag |=> frontReset);

endmodule

// File: rtl/rampdiff_digitizer.sv
module rampdiff_digitizer
  import rd_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int TO_W     = 20,
  parameter int RST_HOLD = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flagA,
  input  logic            flagB,
  input  logic [TO_W-1:0] timeoutLimit,
  output logic            frontReset,
  output logic            pulseWidth,
  output logic [CNT_W:0]  result,
  output logic            resultValid,
  output logic            timeoutFlag
);

  rd_strobe_t strobe;
  logic       aSync;
  logic       bSync;

  rd_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .flagA       (flagA),
    .flagB       (flagB),
    .strobe      (strobe),
    .aSync       (aSync),
    .bSync       (bSync),
    .pulseWidth  (pulseWidth),
    .result      (result),
    .resultValid (resultValid)
  );

  rd_control #(.TO_W(TO_W), .RST_HOLD(RST_HOLD)) ctl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .aSync        (aSync),
    .bSync        (bSync),
    .timeoutLimit (timeoutLimit),
    .strobe       (strobe),
    .frontReset   (frontReset),
    .timeoutFlag  (timeoutFlag)
  );

  assert_reset_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frontReset) |-> (resultValid || timeoutFlag));

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(resultValid && timeoutFlag));

endmodule

// File: tb/rampdiff_digitizer_tb.sv
module rampdiff_digitizer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TB_CNT_W   = 6;
  localparam int TB_TO_W    = 10;
  localparam int TB_HOLD    = 8;
  localparam int LIMIT      = 100;
  localparam int MAXMAG     = (1 << TB_CNT_W) - 1;

  localparam int NV = 7;
  localparam int VGAP [NV] = '{5, 5, 0, 1, 37, 63, 100};
  localparam bit VBF  [NV] = '{0, 1, 0, 0, 1,  0,  1};

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               flagA = 1'b0;
  logic               flagB = 1'b0;
  logic [TB_TO_W-1:0] timeoutLimit = TB_TO_W'(LIMIT);
  logic               frontReset;
  logic               pulseWidth;
  logic [TB_CNT_W:0]  result;
  logic               resultValid;
  logic               timeoutFlag;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rampdiff_digitizer #(.CNT_W(TB_CNT_W), .TO_W(TB_TO_W), .RST_HOLD(TB_HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .flagA(flagA), .flagB(flagB),
    .timeoutLimit(timeoutLimit), .frontReset(frontReset),
    .pulseWidth(pulseWidth), .result(result),
    .resultValid(resultValid), .timeoutFlag(timeoutFlag)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drop both flags at the current negedge; return negedges with frontReset high,
  // counting the current one.
  task automatic release_and_count(output int highCnt);
    highCnt = 0;
    flagA = 1'b0;
    flagB = 1'b0;
    while (frontReset && highCnt < 300) begin
      highCnt++;
      @(negedge clk);
    end
  endtask

  // Wait at negedges until frontReset is low (ready for a new conversion).
  task automatic wait_ready();
    for (int w = 0; w < 300 && frontReset; w++) @(negedge clk);
    @(negedge clk);
  endtask

  // One conversion; leaves flags high at the negedge where the outcome is seen.
  task automatic convert(input int gap, input bit bFirst, output bit gotValid, output bit gotTo);
    gotValid = 0;
    gotTo    = 0;
    @(negedge clk);
    if (gap == 0) begin
      flagA = 1'b1; flagB = 1'b1;
    end else if (bFirst) flagB = 1'b1;
    else flagA = 1'b1;
    for (int i = 1; i <= gap; i++) begin
      @(negedge clk);
      if (i == 3 && gap > 3) check(pulseWidth == 1'b1, "R1 pulse high during gap", pulseWidth, 1);
      if (i == gap) begin
        if (bFirst) flagA = 1'b1;
        else flagB = 1'b1;
      end
    end
    for (int w = 0; w < 40 && !(resultValid || timeoutFlag); w++) @(negedge clk);
    gotValid = resultValid;
    gotTo    = timeoutFlag;
  endtask

  initial begin
    int hc;
    bit gv, gt;
    int expMag;
    bit expSign;

    // R8: power-up reset state
    repeat (3) @(negedge clk);
    check(frontReset == 1'b1, "R8 frontReset during reset", frontReset, 1);
    check(resultValid == 1'b0, "R8 no valid during reset", resultValid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(frontReset == 1'b1, "R8 frontReset after reset release", frontReset, 1);
    wait_ready();
    check(frontReset == 1'b0, "R7 reset self-release after power-up", frontReset, 0);

    // Vector table: gap, first channel
    for (int v = 0; v < NV; v++) begin
      expMag  = (VGAP[v] > MAXMAG) ? MAXMAG : VGAP[v];
      expSign = (VGAP[v] > 0) && VBF[v];
      convert(VGAP[v], VBF[v], gv, gt);
      check(gv == 1'b1, "R6 valid seen", gv, 1);
      check(gt == 1'b0, "R9 no timeout within limit", gt, 0);
      check(frontReset == 1'b1, "R6 reset raised with valid", frontReset, 1);
      check(pulseWidth == 1'b0, "R1 pulse low when both crossed", pulseWidth, 0);
      check(int'(result[TB_CNT_W-1:0]) == expMag, "R2 R4 R5 magnitude",
            int'(result[TB_CNT_W-1:0]), expMag);
      check(result[TB_CNT_W] == expSign, "R3 R4 sign", result[TB_CNT_W], expSign);
      release_and_count(hc);
      check(hc == TB_HOLD, "R7 minimum reset length", hc, TB_HOLD);
      @(negedge clk);
      check(resultValid == 1'b0, "R6 valid single cycle", resultValid, 0);
      wait_ready();
    end

    // R10: synchronizer latency
    @(negedge clk);
    flagA = 1'b1;
    @(negedge clk);
    check(pulseWidth == 1'b0, "R10 not visible after one edge", pulseWidth, 0);
    @(negedge clk);
    check(pulseWidth == 1'b1, "R10 visible after two edges", pulseWidth, 1);
    repeat (4) @(negedge clk);
    flagB = 1'b1;
    for (int w = 0; w < 10 && !resultValid; w++) @(negedge clk);
    check(int'(result[TB_CNT_W-1:0]) == 6, "R2 gap of six", int'(result[TB_CNT_W-1:0]), 6);
    check(result[TB_CNT_W] == 1'b0, "R3 channel A first", result[TB_CNT_W], 0);

    // R7: reset stretched while flags stay high
    repeat (20) @(negedge clk);
    check(frontReset == 1'b1, "R7 reset held while flags high", frontReset, 1);
    flagA = 1'b0; flagB = 1'b0;
    hc = 0;
    @(negedge clk);
    while (frontReset && hc < 50) begin hc++; @(negedge clk); end
    check(hc == 2, "R7 release two edges after flags drop", hc, 2);
    wait_ready();

    // R9: timeout, second channel never crosses
    @(negedge clk);
    flagB = 1'b1;
    gv = 0; gt = 0;
    for (int w = 0; w < 300 && !timeoutFlag; w++) begin
      @(negedge clk);
      if (resultValid) gv = 1;
    end
    gt = timeoutFlag;
    check(gt == 1'b1, "R9 timeout flagged", gt, 1);
    check(gv == 1'b0, "R9 no result on timeout", gv, 0);
    check(frontReset == 1'b1, "R9 reset raised on timeout", frontReset, 1);
    release_and_count(hc);
    wait_ready();

    // Conversion after a timeout still works
    convert(9, 1'b1, gv, gt);
    check(gv == 1'b1, "R6 valid after timeout recovery", gv, 1);
    check(int'(result[TB_CNT_W-1:0]) == 9, "R2 magnitude after recovery",
          int'(result[TB_CNT_W-1:0]), 9);
    check(result[TB_CNT_W] == 1'b1, "R3 channel B first held", result[TB_CNT_W], 1);
    release_and_count(hc);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule